// File: doc/BRIEF.md
# Escaped Serial Command Parser

This block sits between a byte-oriented serial receiver and the registers that drive an LED matrix and a set of level (PWM duty) outputs. Each received byte first passes through an escape filter: a backslash marks the following byte as literal, an escaped `n` becomes a newline data byte, and an unescaped newline terminates whatever command is in progress. The filtered bytes feed a command state machine that recognises single-letter commands. These commands set single LED bits, load a whole frame, store level values, or request a read-back of the frame.

The LED frame is held twice, as a front copy that the display scanner reads and a back copy that bulk loads fill. The two exchange roles when the last byte of a bulk load arrives, so the display never sees a half-written frame. A read-back request produces an ASCII hex dump of the front frame on a ready/valid transmit port. While that dump is in progress, the receive side deasserts its ready so that no incoming byte is dropped.

Top module: `esc_cmd_decoder`

## Requirements
- R1: After reset `frame_o` and `level_o` are all zero, `tx_valid` is low and `rx_ready` is high.
- R2: A backslash (0x5C) that is not itself escaped changes no register and makes the next byte literal. An escaped backslash is delivered as data 0x5C, and any escaped byte other than `n` is delivered unchanged.
- R3: An escaped `n` (0x6E) is delivered to the command parser as data byte 0x0A.
- R4: An unescaped newline (0x0A) abandons the command in progress and returns the parser to command-wait. A partially received bulk load does not swap the frame.
- R5: Command `s` (0x73), index, value: if index < 32, `frame_o[index]` (byte index/8, bit index mod 8) becomes 1 when value is nonzero and 0 otherwise. For index >= 32, nothing changes.
- R6: Command `b` (0x62) followed by four bytes writes them to back bytes 0..3. After the fourth byte the buffers swap, so `frame_o[8k+7:8k]` equals byte k. Single-bit writes from `s` act on the front copy.
- R7: Command `a` (0x61), index, level: an index above 5 is replaced by 0, then `level_o[8i+7:8i]` takes the level byte.
- R8: Command `r` (0x72) transmits `r`, then for front bytes 0..3 the low nibble then the high nibble as ASCII hex with uppercase `A`..`F`, then 0x0A. `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- R9: While a read-back is in progress `rx_ready` is low. A byte offered in that time is taken after the final newline has been handed over, and it is processed normally.
- R10: An unrecognised byte in command-wait changes no register, and the parser stays in command-wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block accepts a byte this cycle |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| frame_o | output | 32 | Front LED frame, bit n is LED n |
| level_o | output | 48 | Six level registers, entry i in bits 8i+7:8i |

## Verification
A byte is consumed on the rising edge where `rx_valid` and `rx_ready` are both high. `frame_o` and `level_o` already show its effect one edge later, since the escape filter and command decoder are combinational in front of the registers. The bench therefore drives on the falling edge and checks registers at the falling edge after the accepting edge. `tx_valid` rises the cycle after `r` is accepted. Each transmitted byte is recorded at the falling edge before the rising edge that completes its handshake. During a read-back, `rx_ready` is sampled at a falling edge to confirm the hold, and the count of transmitted characters is taken when the held byte is finally accepted; it must already be ten.

// File: rtl/esc_cmd_pkg.sv
package esc_cmd_pkg;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_LED_IDX,
      ST_LED_VAL,
      ST_FILL,
      ST_LVL_IDX,
      ST_LVL_VAL
   } parse_st_t;

   localparam logic [7:0] CH_BSLASH = 8'h5C;
   localparam logic [7:0] CH_NL     = 8'h0A;
   localparam logic [7:0] CH_LOW_N  = 8'h6E;
   localparam logic [7:0] OP_SET    = 8'h73;
   localparam logic [7:0] OP_BULK   = 8'h62;
   localparam logic [7:0] OP_LEVEL  = 8'h61;
   localparam logic [7:0] OP_READ   = 8'h72;

   function automatic logic [7:0] nib_ascii(input logic [3:0] n);
      return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
   endfunction

endpackage

// File: rtl/esc_unescape.sv
module esc_unescape
   import esc_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_fire,
   input  logic [7:0] in_byte,
   output logic       out_valid,
   output logic [7:0] out_byte,
   output logic       out_eol
);
   logic esc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       esc_q <= 1'b0;
      else if (in_fire) esc_q <= !esc_q && (in_byte == CH_BSLASH);
   end

   always_comb begin
      out_eol   = in_fire && !esc_q && (in_byte == CH_NL);
      out_valid = in_fire && (esc_q || ((in_byte != CH_BSLASH) && (in_byte != CH_NL)));
      out_byte  = (esc_q && (in_byte == CH_LOW_N)) ? CH_NL : in_byte;
   end
endmodule

// File: rtl/esc_frame_store.sv
module esc_frame_store #(
   parameter int FRAME_BYTES     = 4,
   parameter bit SWAP_BY_POINTER = 1'b1,
   localparam int FW    = FRAME_BYTES * 8,
   localparam int BIT_W = $clog2(FW),
   localparam int SEL_W = $clog2(FRAME_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_we,
   input  logic [BIT_W-1:0] bit_idx,
   input  logic             bit_val,
   input  logic             back_we,
   input  logic [SEL_W-1:0] back_idx,
   input  logic [7:0]       back_byte,
   input  logic             swap,
   output logic [FW-1:0]    front
);
   generate
      if (SWAP_BY_POINTER) begin : g_ptr
         logic          sel_q;
         logic [FW-1:0] bank0_q, bank1_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_q   <= 1'b0;
               bank0_q <= '0;
               bank1_q <= '0;
            end else begin
               if (bit_we && !sel_q)  bank0_q[bit_idx] <= bit_val;
               if (bit_we && sel_q)   bank1_q[bit_idx] <= bit_val;
               if (back_we && sel_q)  bank0_q[{back_idx, 3'b000} +: 8] <= back_byte;
               if (back_we && !sel_q) bank1_q[{back_idx, 3'b000} +: 8] <= back_byte;
               if (swap)              sel_q <= !sel_q;
            end
         end
         assign front = sel_q ? bank1_q : bank0_q;
      end else begin : g_copy
         logic [FW-1:0] front_q, back_q, front_nx, back_nx;
         always_comb begin
            front_nx = front_q;
            back_nx  = back_q;
            if (bit_we)  front_nx[bit_idx] = bit_val;
            if (back_we) back_nx[{back_idx, 3'b000} +: 8] = back_byte;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               front_q <= '0;
               back_q  <= '0;
            end else if (swap) begin
               front_q <= back_nx;
               back_q  <= front_nx;
            end else begin
               front_q <= front_nx;
               back_q  <= back_nx;
            end
         end
         assign front = front_q;
      end
   endgenerate
endmodule

// File: rtl/esc_hex_tx.sv
module esc_hex_tx
   import esc_cmd_pkg::*;
#(
   parameter int FRAME_BYTES = 4,
   localparam int FW    = FRAME_BYTES * 8,
   localparam int LAST  = 2 * FRAME_BYTES + 1,
   localparam int CNT_W = $clog2(LAST + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [FW-1:0] frame,
   input  logic          tx_ready,
   output logic          tx_valid,
   output logic [7:0]    tx_data
);
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] k;
   logic [7:0]       cur_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q && tx_ready) begin
         if (cnt_q == CNT_W'(LAST)) busy_q <= 1'b0;
         else                       cnt_q  <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      k        = cnt_q - 1'b1;
      cur_byte = '0;
      for (int j = 0; j < FRAME_BYTES; j++)
         if (k[CNT_W-1:1] == (CNT_W-1)'(j)) cur_byte = frame[8*j +: 8];
      if (cnt_q == '0)                tx_data = OP_READ;
      else if (cnt_q == CNT_W'(LAST)) tx_data = CH_NL;
      else                            tx_data = nib_ascii(k[0] ? cur_byte[7:4] : cur_byte[3:0]);
   end

   assign tx_valid = busy_q;
endmodule

// File: rtl/esc_cmd_decoder.sv
module esc_cmd_decoder
   import esc_cmd_pkg::*;
#(
   parameter int LED_COUNT       = 32,
   parameter int LEVEL_COUNT     = 6,
   parameter bit SWAP_BY_POINTER = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [7:0]               rx_data,
   input  logic                     rx_valid,
   output logic                     rx_ready,
   output logic [7:0]               tx_data,
   output logic                     tx_valid,
   input  logic                     tx_ready,
   output logic [LED_COUNT-1:0]     frame_o,
   output logic [LEVEL_COUNT*8-1:0] level_o
);
   localparam int FRAME_BYTES = LED_COUNT / 8;
   localparam int BIT_W       = $clog2(LED_COUNT);
   localparam int SEL_W       = $clog2(FRAME_BYTES);
   localparam logic [8:0] LED_LIM = 9'(LED_COUNT);
   localparam logic [7:0] LVL_MAX = 8'(LEVEL_COUNT - 1);

   generate
      if (LED_COUNT % 8 != 0 || LED_COUNT < 16 || LED_COUNT > 256) begin : g_bad_leds
         $error("LED_COUNT must be a multiple of 8 in 16..256");
      end
      if (LEVEL_COUNT < 1 || LEVEL_COUNT > 256) begin : g_bad_levels
         $error("LEVEL_COUNT must be in 1..256");
      end
   endgenerate

   logic       fire, dv, eol, start;
   logic [7:0] d;
   parse_st_t  st_q;
   logic [7:0] arg_q;
   logic [SEL_W-1:0] fill_q;
   logic       bit_we, back_we, swap;

   assign fire = rx_valid && rx_ready;
   assign rx_ready = !tx_valid;

   esc_unescape u_unesc (
      .clk(clk), .rst_n(rst_n), .in_fire(fire), .in_byte(rx_data),
      .out_valid(dv), .out_byte(d), .out_eol(eol)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_WAIT;
         arg_q  <= '0;
         fill_q <= '0;
      end else if (eol) begin
         st_q <= ST_WAIT;
      end else if (dv) begin
         unique case (st_q)
            ST_WAIT: begin
               if (d == OP_SET)   st_q <= ST_LED_IDX;
               if (d == OP_LEVEL) st_q <= ST_LVL_IDX;
               if (d == OP_BULK) begin
                  st_q   <= ST_FILL;
                  fill_q <= '0;
               end
            end
            ST_LED_IDX: begin
               arg_q <= d;
               st_q  <= ST_LED_VAL;
            end
            ST_FILL: begin
               fill_q <= fill_q + 1'b1;
               if (fill_q == SEL_W'(FRAME_BYTES - 1)) st_q <= ST_WAIT;
            end
            ST_LVL_IDX: begin
               arg_q <= (d > LVL_MAX) ? 8'h00 : d;
               st_q  <= ST_LVL_VAL;
            end
            default: st_q <= ST_WAIT;
         endcase
      end
   end

   assign bit_we  = dv && (st_q == ST_LED_VAL) && ({1'b0, arg_q} < LED_LIM);
   assign back_we = dv && (st_q == ST_FILL);
   assign swap    = back_we && (fill_q == SEL_W'(FRAME_BYTES - 1));
   assign start   = dv && (st_q == ST_WAIT) && (d == OP_READ);

   esc_frame_store #(.FRAME_BYTES(FRAME_BYTES), .SWAP_BY_POINTER(SWAP_BY_POINTER)) u_store (
      .clk(clk), .rst_n(rst_n),
      .bit_we(bit_we), .bit_idx(arg_q[BIT_W-1:0]), .bit_val(d != 8'h00),
      .back_we(back_we), .back_idx(fill_q), .back_byte(d),
      .swap(swap), .front(frame_o)
   );

   generate
      for (genvar i = 0; i < LEVEL_COUNT; i++) begin : g_lvl
         logic [7:0] lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= '0;
            else if (dv && !eol && (st_q == ST_LVL_VAL) && (arg_q == 8'(i))) lvl_q <= d;
         end
         assign level_o[8*i +: 8] = lvl_q;
      end
   endgenerate

   esc_hex_tx #(.FRAME_BYTES(FRAME_BYTES)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .frame(frame_o),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
   );
endmodule

// File: rtl/esc_cmd_checker.sv
module esc_cmd_checker #(
   parameter int LED_COUNT   = 32,
   parameter int LEVEL_COUNT = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     rx_valid,
   input logic                     rx_ready,
   input logic [7:0]               tx_data,
   input logic                     tx_valid,
   input logic                     tx_ready,
   input logic [LED_COUNT-1:0]     frame_o,
   input logic [LEVEL_COUNT*8-1:0] level_o
);
   p_rx_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !rx_ready);

   p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   p_tx_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> (tx_data == 8'h72));

   p_tx_charset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> ((tx_data == 8'h72) || (tx_data == 8'h0A) ||
                    (tx_data >= 8'h30 && tx_data <= 8'h39) ||
                    (tx_data >= 8'h41 && tx_data <= 8'h46)));

   p_frame_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_ready) |=> $stable(frame_o));

   p_level_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_ready) |=> $stable(level_o));
endmodule

bind esc_cmd_decoder esc_cmd_checker #(.LED_COUNT(LED_COUNT), .LEVEL_COUNT(LEVEL_COUNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
   .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
   .frame_o(frame_o), .level_o(level_o)
);

// File: tb/sim_esc_cmd_decoder.sv
`timescale 1ns/1ps
module sim_esc_cmd_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b1;
   logic [31:0] frame_o;
   logic [47:0] level_o;

   int errors = 0;
   int checks = 0;
   bit stall_mode = 1'b0;
   logic [7:0] cap [16];
   int cap_n = 0;
   logic [31:0] m_front = '0, m_back = '0;
   logic [7:0]  m_lvl [6];

   always #4 clk = ~clk;

   esc_cmd_decoder u0 (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .frame_o(frame_o), .level_o(level_o)
   );

   always @(posedge clk) begin
      #1;
      tx_ready = stall_mode ? ~tx_ready : 1'b1;
   end

   always @(negedge clk)
      if (tx_valid && tx_ready && cap_n < 16) begin
         cap[cap_n] = tx_data;
         cap_n = cap_n + 1;
      end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_data = b;
      rx_valid = 1'b1;
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
      #1 rx_valid = 1'b0;
   endtask

   task automatic check_state(input string req);
      @(negedge clk);
      check({req, " frame"}, {32'h0, frame_o}, {32'h0, m_front});
      for (int i = 0; i < 6; i++)
         check({req, " level"}, {56'h0, level_o[8*i +: 8]}, {56'h0, m_lvl[i]});
   endtask

   function automatic logic [7:0] hx(input logic [3:0] n);
      string s = "0123456789ABCDEF";
      return s[n];
   endfunction

   task automatic t_reset;
      @(negedge clk);
      check("R1 frame", {32'h0, frame_o}, 64'h0);
      check("R1 level", {16'h0, level_o}, 64'h0);
      check("R1 tx_valid", {63'h0, tx_valid}, 64'h0);
      check("R1 rx_ready", {63'h0, rx_ready}, 64'h1);
   endtask

   task automatic t_led;
      send(8'h73); send(8'd5);  send(8'h01); m_front[5]  = 1'b1; check_state("R5 set bit5");
      send(8'h73); send(8'd31); send(8'hFF); m_front[31] = 1'b1; check_state("R5 set bit31");
      send(8'h73); send(8'd13); send(8'h00);                     check_state("R5 clear unset");
      send(8'h73); send(8'd5);  send(8'h00); m_front[5]  = 1'b0; check_state("R5 clear bit5");
      send(8'h73); send(8'd40); send(8'h01);                     check_state("R5 index 40 ignored");
   endtask

   task automatic t_escape;
      send(8'h61); send(8'd2); send(8'h5C); send(8'h6E); m_lvl[2] = 8'h0A; check_state("R3 escaped n");
      send(8'h61); send(8'd3); send(8'h5C); send(8'h5C); m_lvl[3] = 8'h5C; check_state("R2 escaped backslash");
      send(8'h61); send(8'd4); send(8'h5C); send(8'h51); m_lvl[4] = 8'h51; check_state("R2 escaped other");
      send(8'h5C); check_state("R2 lone backslash no change");
      send(8'h73); send(8'd9); send(8'h01); m_front[9] = 1'b1; check_state("R2 escaped command letter");
   endtask

   task automatic t_level;
      send(8'h61); send(8'd9); send(8'h33); m_lvl[0] = 8'h33; check_state("R7 index 9 forced to 0");
      send(8'h61); send(8'd5); send(8'h44); m_lvl[5] = 8'h44; check_state("R7 index 5");
      send(8'h61); send(8'd6); send(8'h55); m_lvl[0] = 8'h55; check_state("R7 index 6 forced to 0");
   endtask

   task automatic bulk(input logic [31:0] w);
      send(8'h62);
      for (int k = 0; k < 4; k++) send(w[8*k +: 8]);
      m_back = m_front;
      m_front = w;
   endtask

   task automatic t_bulk;
      bulk(32'h44332211); check_state("R6 first load");
      send(8'h73); send(8'd0); send(8'h00); m_front[0] = 1'b0; check_state("R6 bit write on front");
      send(8'h62); send(8'h5C); send(8'h6E); send(8'h10); send(8'h20); send(8'h30);
      m_back = m_front; m_front = 32'h3020100A; check_state("R3 escaped n in load");
   endtask

   task automatic t_abort;
      send(8'h62); send(8'hAA); send(8'hBB); send(8'hCC); send(8'h0A);
      check_state("R4 partial load no swap");
      send(8'h73); send(8'd7); send(8'h0A); send(8'h01);
      check_state("R4 set aborted");
      send(8'h61); send(8'h0A); send(8'h20);
      check_state("R4 level aborted");
      bulk(32'h04030201); check_state("R4 load after abort");
   endtask

   task automatic t_unknown;
      send(8'h7A); check_state("R10 unknown byte");
      send(8'h78); send(8'h73); send(8'd18); send(8'h01); m_front[18] = 1'b1;
      check_state("R10 idle after unknown");
   endtask

   task automatic check_dump(input string req);
      int n = 0;
      while (cap_n < 10 && n < 200) begin @(negedge clk); n++; end
      check({req, " char count"}, 64'(cap_n), 64'd10);
      check({req, " lead"}, {56'h0, cap[0]}, 64'h72);
      for (int b = 0; b < 4; b++) begin
         check({req, " lo nibble"}, {56'h0, cap[1+2*b]}, {56'h0, hx(m_front[8*b +: 4])});
         check({req, " hi nibble"}, {56'h0, cap[2+2*b]}, {56'h0, hx(m_front[8*b+4 +: 4])});
      end
      check({req, " trailer"}, {56'h0, cap[9]}, 64'h0A);
   endtask

   task automatic t_read;
      bulk(32'hC0FFEE5A);
      cap_n = 0;
      send(8'h72);
      check_dump("R8 plain");
   endtask

   task automatic t_read_hold;
      int at_accept;
      stall_mode = 1'b1;
      cap_n = 0;
      send(8'h72);
      @(negedge clk);
      check("R9 rx_ready low during dump", {63'h0, rx_ready}, 64'h0);
      send(8'h73);
      at_accept = cap_n;
      check("R9 byte taken after dump", 64'(at_accept), 64'd10);
      send(8'd1); send(8'h01);
      check_dump("R8 stalled");
      m_front[1] = 1'b1;
      stall_mode = 1'b0;
      check_state("R9 held command applied");
   endtask

   initial begin
      for (int i = 0; i < 6; i++) m_lvl[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset;
      t_led;
      t_escape;
      t_level;
      t_bulk;
      t_abort;
      t_unknown;
      t_read;
      t_read_hold;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule